// File: doc/BRIEF.md
# Two-Sided Sync Doorbell Register

This block links two processors through a pair of mirrored 32-bit sync registers, one per side. Each side owns a 4-bit outgoing value that the other side sees in the low nibble of its own register, so small status codes can be passed back and forth without a queue. Each side can also ring the other side's doorbell by writing a one-shot bit. The doorbell reaches the far side's interrupt output only when that far side has enabled it.

Each side has a plain register port: a select strobe, a write flag, 32-bit write data and 32-bit read data. Read data is always driven from the current register state. A write is taken on the clock edge where both select and write are high. Each side also has an interrupt output, which is a sticky pending flag, and an acknowledge input that clears it. Both sides share one clock and one active-low reset. No port carries a data stream, so no handshake is used.

Top module: `sync_doorbell_pair`

## Requirements
- R1: After reset, both read-data buses are 0 and both interrupt outputs are 0.
- R2: Bits 11:8 of a side's register are read/write. They keep the last value written with select and write high, and read back on the same side in the cycle after the write edge.
- R3: Bits 3:0 of a side's register are read-only and show the other side's bits 11:8. They follow a write on the other side in the cycle after its write edge. Writing bits 3:0 has no effect.
- R4: Writing 1 to bit 13 sends one doorbell request to the other side. Writing 0 to bit 13 sends none. Bit 13 always reads 0.
- R5: Bit 14 is a read/write interrupt enable. When a doorbell write happens on the far side and this side's enable is 1 at the following edge, this side's interrupt output is high from the second cycle after the far side's write edge.
- R6: A doorbell that arrives while the receiving side's enable is 0 is dropped. Setting the enable later does not raise the interrupt.
- R7: The interrupt output stays high until the acknowledge input is sampled high, and is low in the cycle after that edge. If a new request arrives on the same edge as the acknowledge, the request wins and the output stays high.
- R8: Bits 31:15 and bit 12 read 0, and writing them has no effect. Bits 7:4 also read 0.
- R9: When select is low, or write is low, nothing in the register changes and no doorbell is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low reset |
| a_sel | input | 1 | Side A register select |
| a_wr | input | 1 | Side A write flag |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_ack | input | 1 | Side A interrupt acknowledge |
| a_irq | output | 1 | Side A pending interrupt |
| b_sel | input | 1 | Side B register select |
| b_wr | input | 1 | Side B write flag |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_ack | input | 1 | Side B interrupt acknowledge |
| b_irq | output | 1 | Side B pending interrupt |

## Verification
Register fields, including the other side's nibble, are due one cycle after the write edge. A doorbell is due on the far interrupt two cycles after the write edge, because the request is registered once and then the pending flag is registered. An acknowledge clears the interrupt one cycle after its edge. The bench drives inputs on falling edges and samples on falling edges. Each check is placed at the exact due cycle, and the cycle before is also checked where the delay matters, for example that the interrupt is still low one cycle after a doorbell write.

// File: rtl/sync_doorbell_pkg.sv
package sync_doorbell_pkg;
  localparam int DATA_W   = 32;
  localparam int NIB_W    = 4;
  localparam int IN_LSB   = 0;
  localparam int OUT_LSB  = 8;
  localparam int RING_BIT = 13;
  localparam int EN_BIT   = 14;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/sdb_pending.sv
module sdb_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (req_in && enable) pend_q <= 1'b1;
    else if (ack)              pend_q <= 1'b0;
  end

  assign pending = pend_q;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in && enable) |=> pending); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !(req_in && enable)) |=> !pending); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending); // R7
endmodule

// File: rtl/sdb_side.sv
module sdb_side
  import sync_doorbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NIB_W-1:0]  nib_in,
  input  logic              req_in,
  input  logic              ack,
  output logic [NIB_W-1:0]  nib_out,
  output logic              req_out,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);
  logic             wr_en;
  logic [NIB_W-1:0] nib_q;
  logic             en_q;
  logic             ring_q;

  assign wr_en = sel && wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q  <= '0;
      en_q   <= 1'b0;
      ring_q <= 1'b0;
    end else begin
      ring_q <= wr_en && wdata[RING_BIT];
      if (wr_en) begin
        nib_q <= wdata[OUT_LSB +: NIB_W];
        en_q  <= wdata[EN_BIT];
      end
    end
  end

  always_comb begin
    rdata                   = '0;
    rdata[IN_LSB +: NIB_W]  = nib_in;
    rdata[OUT_LSB +: NIB_W] = nib_q;
    rdata[EN_BIT]           = en_q;
  end

  assign nib_out = nib_q;
  assign req_out = ring_q;

  sdb_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (req_in),
    .enable  (en_q),
    .ack     (ack),
    .pending (irq)
  );

  AST_RING_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> $past(sel && wr && wdata[RING_BIT])); // R4
  AST_NIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> $stable(nib_out)); // R9
  AST_RING_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[RING_BIT] == 1'b0); // R4
endmodule

// File: rtl/sync_doorbell_pair.sv
module sync_doorbell_pair
  import sync_doorbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic              a_wr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              a_ack,
  output logic              a_irq,
  input  logic              b_sel,
  input  logic              b_wr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  input  logic              b_ack,
  output logic              b_irq
);
  logic              sel_v   [NUM_SIDES];
  logic              wr_v    [NUM_SIDES];
  logic [DATA_W-1:0] wdata_v [NUM_SIDES];
  logic [DATA_W-1:0] rdata_v [NUM_SIDES];
  logic              ack_v   [NUM_SIDES];
  logic              irq_v   [NUM_SIDES];
  logic [NIB_W-1:0]  nib_v   [NUM_SIDES];
  logic              req_v   [NUM_SIDES];

  assign sel_v[0] = a_sel;   assign sel_v[1] = b_sel;
  assign wr_v[0]  = a_wr;    assign wr_v[1]  = b_wr;
  assign wdata_v[0] = a_wdata; assign wdata_v[1] = b_wdata;
  assign ack_v[0] = a_ack;   assign ack_v[1] = b_ack;
  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];
  assign a_irq   = irq_v[0];
  assign b_irq   = irq_v[1];

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    localparam int FAR = NUM_SIDES - 1 - g;
    sdb_side u_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_v[g]),
      .wr      (wr_v[g]),
      .wdata   (wdata_v[g]),
      .nib_in  (nib_v[FAR]),
      .req_in  (req_v[FAR]),
      .ack     (ack_v[g]),
      .nib_out (nib_v[g]),
      .req_out (req_v[g]),
      .irq     (irq_v[g]),
      .rdata   (rdata_v[g])
    );
  end

  AST_CROSS_NIB_A: assert property (@(posedge clk) disable iff (!rst_n)
    a_rdata[NIB_W-1:0] == b_rdata[OUT_LSB +: NIB_W]); // R3
  AST_CROSS_NIB_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_rdata[NIB_W-1:0] == a_rdata[OUT_LSB +: NIB_W]); // R3
endmodule

// File: tb/tb_sync_doorbell_pair.sv
`timescale 1ns/1ps
module tb_sync_doorbell_pair;
  logic clk = 0;
  logic rst_n = 0;
  logic        sel [2];
  logic        wr  [2];
  logic [31:0] wd  [2];
  logic        ack [2];
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  sync_doorbell_pair dut (
    .clk(clk), .rst_n(rst_n),
    .a_sel(sel[0]), .a_wr(wr[0]), .a_wdata(wd[0]), .a_rdata(a_rdata),
    .a_ack(ack[0]), .a_irq(a_irq),
    .b_sel(sel[1]), .b_wr(wr[1]), .b_wdata(wd[1]), .b_rdata(b_rdata),
    .b_ack(ack[1]), .b_irq(b_irq)
  );

  function automatic logic [31:0] rd(int s);
    return (s == 0) ? a_rdata : b_rdata;
  endfunction
  function automatic logic irq_of(int s);
    return (s == 0) ? a_irq : b_irq;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle strobe; returns at the falling edge after the write edge
  task automatic reg_write(int s, logic [31:0] d, logic s_en = 1, logic w_en = 1);
    @(negedge clk);
    sel[s] = s_en; wr[s] = w_en; wd[s] = d;
    @(negedge clk);
    sel[s] = 0; wr[s] = 0; wd[s] = 0;
  endtask

  task automatic pulse_ack(int s);
    @(negedge clk); ack[s] = 1;
    @(negedge clk); ack[s] = 0;
  endtask

  task automatic t_reset;
    check("R1 a_rdata", a_rdata, 0);
    check("R1 b_rdata", b_rdata, 0);
    check("R1 irq", {30'b0, a_irq, b_irq}, 0);
  endtask

  task automatic t_nibbles;
    reg_write(0, 32'h0000_0A00);
    check("R2 A readback", a_rdata, 32'h0000_0A00);
    check("R3 B sees A nibble", b_rdata, 32'h0000_000A);
    reg_write(1, 32'h0000_050F);
    check("R3 A sees B nibble, low write ignored", a_rdata, 32'h0000_0A05);
    check("R3 B own low bits untouched", b_rdata, 32'h0000_050A);
  endtask

  task automatic t_reserved;
    reg_write(0, 32'hFFFF_90F3 & ~32'h0000_4000 | 32'h0000_0300);
    check("R8 reserved bits read 0", a_rdata, 32'h0000_0305);
    check("R4 ring bit reads 0", a_rdata[13], 0);
  endtask

  task automatic t_no_strobe;
    reg_write(0, 32'h0000_6C00, 1'b0, 1'b1);
    check("R9 sel low ignored", a_rdata, 32'h0000_0305);
    reg_write(0, 32'h0000_6C00, 1'b1, 1'b0);
    check("R9 wr low ignored", a_rdata, 32'h0000_0305);
    @(negedge clk);
    check("R9 no doorbell", b_irq, 0);
  endtask

  task automatic t_ring_enabled;
    reg_write(1, 32'h0000_4500);           // B enables, nibble 5
    check("R5 enable readback", b_rdata, 32'h0000_4503);
    reg_write(0, 32'h0000_2300);           // A rings B
    check("R5 irq not yet", b_irq, 0);
    @(negedge clk);
    check("R5 irq due", b_irq, 1);
    check("R4 no echo to sender", a_irq, 0);
    repeat (3) @(negedge clk);
    check("R7 sticky", b_irq, 1);
    pulse_ack(1);
    check("R7 ack clears", b_irq, 0);
    reg_write(0, 32'h0000_0300);           // bit13 = 0
    repeat (2) @(negedge clk);
    check("R4 zero sends nothing", b_irq, 0);
  endtask

  task automatic t_ring_masked;
    reg_write(0, 32'h0000_0300);           // A enable stays 0
    reg_write(1, 32'h0000_2500);           // B rings A, also clears B enable
    repeat (2) @(negedge clk);
    check("R6 masked request dropped", a_irq, 0);
    reg_write(0, 32'h0000_4300);
    repeat (2) @(negedge clk);
    check("R6 late enable no irq", a_irq, 0);
  endtask

  task automatic t_ack_collision;
    reg_write(1, 32'h0000_2500);           // B rings A (A enabled)
    @(negedge clk);
    check("R5 A irq due", a_irq, 1);
    reg_write(1, 32'h0000_2500);           // second ring
    ack[0] = 1;                            // ack on same edge as request
    @(negedge clk); ack[0] = 0;
    check("R7 request beats ack", a_irq, 1);
    pulse_ack(0);
    check("R7 final clear", a_irq, 0);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      sel[s] = 0; wr[s] = 0; wd[s] = 0; ack[s] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_nibbles();
    t_reserved();
    t_no_strobe();
    t_ring_enabled();
    t_ring_masked();
    t_ack_collision();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule